// File: doc/BRIEF.md
# Selection Sequence Packet Receiver

This block sits behind an escape detector on a two-wire debug port. Once a selection escape pulse arms it, it takes one bit from the data/mode line on each bit strobe and assembles the selection packet. The packet starts with a 4-bit activation code and a 4-bit extension code. It may then carry a 24-bit global register image. A 4-bit check packet always closes it. Bit 3 of the extension code picks the form. When that bit is 0 the packet is long and the 24-bit image is present. When it is 1 the packet is short and goes straight to the check packet.

When the last check bit arrives, the receiver loads its captured fields into its output registers and raises a one-cycle valid strobe. A reset escape at any point drops the packet in progress and returns the receiver to idle without a strobe. The escape detector and whatever consumes the configuration are outside this block.

Top module: `selseq_rx`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), `cfg_valid` is 0 and `act_code`, `ext_code`, `glob_cfg` and `chk_code` are all 0.
- R2: While idle, bit strobes are ignored. No field output changes and no `cfg_valid` appears until `sel_pulse` arms the receiver.
- R3: After arming, the first 4 strobed bits form `act_code` and the next 4 form `ext_code`. Each field is received least significant bit first: the first bit of a field lands at bit 0.
- R4: When `ext_code` bit 3 is 0 (long form), the next 24 strobed bits form `glob_cfg`, least significant bit first. Only then does the 4-bit check packet follow.
- R5: When `ext_code` bit 3 is 1 (short form), the check packet follows the extension code directly. `glob_cfg` keeps the value from the last completed long packet.
- R6: The 4 check bits form `chk_code`, least significant bit first. `cfg_valid` is high for exactly one cycle: the cycle after the edge that samples the last check bit. All outputs update on that same edge.
- R7: A `rst_esc` pulse aborts any packet in progress and returns the receiver to idle. It takes priority over a bit strobe or selection pulse in the same cycle. An aborted packet never produces `cfg_valid` and leaves the outputs unchanged.
- R8: A `sel_pulse` that arrives during a packet restarts collection from the first activation-code bit. A strobe in the same cycle is ignored.
- R9: All-zero fields are valid. An all-zero activation code and an all-zero 24-bit image complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe: bit_in holds the next packet bit |
| bit_in | input | 1 | Sampled data/mode line bit |
| sel_pulse | input | 1 | Selection escape seen; arm or restart the receiver |
| rst_esc | input | 1 | Reset escape seen; abort to idle |
| act_code | output | 4 | Activation code of the last completed packet |
| ext_code | output | 4 | Extension code of the last completed packet |
| glob_cfg | output | 24 | Global register image of the last completed long packet |
| chk_code | output | 4 | Check packet of the last completed packet |
| cfg_valid | output | 1 | One-cycle strobe: a packet has completed |

## Verification
The hardest case to reach from the ports is a reset escape that lands in the same cycle as the final check-bit strobe. That edge would otherwise complete the packet, so the escape must win. The stimulus replays a full long packet and raises `rst_esc` together with the last strobe. A separate run aborts halfway and then sends the remaining bits with no new arming. A short packet sent after a long one shows that the image register keeps its old value. A selection pulse issued partway through a packet shows that the partial bits are discarded.

// File: rtl/selseq_pkg.sv
// Shared field widths and controller states for the selection packet receiver.
package selseq_pkg;
    localparam int ACT_W     = 4;
    localparam int EXT_W     = 4;
    localparam int GLB_W     = 24;
    localparam int CHK_W     = 4;
    localparam int SHORT_BIT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_EXT,
        ST_GLB,
        ST_CHK
    } sel_state_t;
endpackage

// File: rtl/selseq_shreg.sv
// LSB-first field shift register.
// What it does: each shift moves the stored bits down one place and puts the
// new bit at the top, so after W shifts the first bit received sits at bit 0.
// nxt_o shows the value the register will hold after a shift with the current
// bit, so the caller can capture a field on the same edge as its last bit.
// Assumes W >= 2.
module selseq_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o
);
    // Value after a shift with the present input bit.
    always_comb nxt_o = {bit_i, q_o[W-1:1]};

    // Register the field contents.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= '0;
        else if (shift_i) q_o <= nxt_o;
    end
endmodule

// File: rtl/selseq_ctrl.sv
// Sequencing controller for the selection packet.
// What it does: walks through the activation, extension, optional image and
// check fields. It counts strobed bits inside each field and raises one shift
// enable for the field in progress. On the last extension bit it uses the
// form bit to choose the long or the short path.
// Assumes: rst_esc outranks sel_i, and sel_i outranks bit_stb. The strobes
// are one cycle wide.
module selseq_ctrl
    import selseq_pkg::*;
#(
    parameter int AW = ACT_W,
    parameter int EW = EXT_W,
    parameter int GW = GLB_W,
    parameter int CW = CHK_W,
    parameter int SB = SHORT_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_i,
    input  logic          sel_i,
    input  logic          esc_i,
    input  logic [EW-1:0] ext_nxt_i,
    output logic          en_act_o,
    output logic          en_ext_o,
    output logic          en_glb_o,
    output logic          en_chk_o,
    output logic          done_o,
    output logic          long_o
);
    localparam int MAXW = (GW > AW && GW > EW && GW > CW) ? GW :
                          ((AW > EW) ? ((AW > CW) ? AW : CW) : ((EW > CW) ? EW : CW));
    localparam int CNTW = $clog2(MAXW);

    sel_state_t      state_q;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] fld_last;
    logic            take;
    logic            last;

    // Index of the last bit in the current field.
    always_comb begin
        case (state_q)
            ST_ACT:  fld_last = CNTW'(AW - 1);
            ST_EXT:  fld_last = CNTW'(EW - 1);
            ST_GLB:  fld_last = CNTW'(GW - 1);
            default: fld_last = CNTW'(CW - 1);
        endcase
    end

    // A strobe counts only while collecting, with no escape or restart pending.
    always_comb begin
        take     = stb_i && !sel_i && !esc_i && (state_q != ST_IDLE);
        last     = (cnt_q == fld_last);
        en_act_o = take && (state_q == ST_ACT);
        en_ext_o = take && (state_q == ST_EXT);
        en_glb_o = take && (state_q == ST_GLB);
        en_chk_o = take && (state_q == ST_CHK);
        done_o   = en_chk_o && last;
    end

    // Advance the state and the bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            long_o  <= 1'b0;
        end else if (esc_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (sel_i) begin
            state_q <= ST_ACT;
            cnt_q   <= '0;
        end else if (take) begin
            if (last) begin
                cnt_q <= '0;
                case (state_q)
                    ST_ACT:  state_q <= ST_EXT;
                    ST_EXT: begin
                        long_o  <= !ext_nxt_i[SB];
                        state_q <= ext_nxt_i[SB] ? ST_CHK : ST_GLB;
                    end
                    ST_GLB:  state_q <= ST_CHK;
                    default: state_q <= ST_IDLE;
                endcase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_act_o, en_ext_o, en_glb_o, en_chk_o})); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(en_act_o || en_ext_o || en_glb_o || en_chk_o)); // R2
    AST_ESC_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        esc_i |=> (state_q == ST_IDLE)); // R7
    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !esc_i) |=> (state_q == ST_ACT && cnt_q == '0)); // R8
    AST_SHORT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ext_o && last && ext_nxt_i[SB]) |=> (state_q == ST_CHK)); // R5
    AST_LONG_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ext_o && last && !ext_nxt_i[SB]) |=> (state_q == ST_GLB)); // R4
endmodule

// File: rtl/selseq_rx.sv
// Selection sequence packet receiver (top).
// What it does: shifts strobed bits into one staging register per field,
// steered by the controller. When the last check bit arrives, it copies the
// fields into the output registers and pulses cfg_valid. A short packet
// leaves the image output untouched.
// Assumes: bit_stb, sel_pulse and rst_esc are single-cycle pulses
// synchronous to clk.
module selseq_rx
    import selseq_pkg::*;
#(
    parameter int AW = ACT_W,
    parameter int EW = EXT_W,
    parameter int GW = GLB_W,
    parameter int CW = CHK_W,
    parameter int SB = SHORT_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_stb,
    input  logic          bit_in,
    input  logic          sel_pulse,
    input  logic          rst_esc,
    output logic [AW-1:0] act_code,
    output logic [EW-1:0] ext_code,
    output logic [GW-1:0] glob_cfg,
    output logic [CW-1:0] chk_code,
    output logic          cfg_valid
);
    logic          en_act, en_ext, en_glb, en_chk, done, long_q;
    logic [AW-1:0] act_q, act_nxt;
    logic [EW-1:0] ext_q, ext_nxt;
    logic [GW-1:0] glb_q, glb_nxt;
    logic [CW-1:0] chk_q, chk_nxt;

    selseq_ctrl #(.AW(AW), .EW(EW), .GW(GW), .CW(CW), .SB(SB)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .stb_i(bit_stb), .sel_i(sel_pulse),
        .esc_i(rst_esc), .ext_nxt_i(ext_nxt),
        .en_act_o(en_act), .en_ext_o(en_ext), .en_glb_o(en_glb),
        .en_chk_o(en_chk), .done_o(done), .long_o(long_q)
    );

    selseq_shreg #(.W(AW)) act_sr_i (.clk(clk), .rst_n(rst_n), .shift_i(en_act),
        .bit_i(bit_in), .q_o(act_q), .nxt_o(act_nxt));
    selseq_shreg #(.W(EW)) ext_sr_i (.clk(clk), .rst_n(rst_n), .shift_i(en_ext),
        .bit_i(bit_in), .q_o(ext_q), .nxt_o(ext_nxt));
    selseq_shreg #(.W(GW)) glb_sr_i (.clk(clk), .rst_n(rst_n), .shift_i(en_glb),
        .bit_i(bit_in), .q_o(glb_q), .nxt_o(glb_nxt));
    selseq_shreg #(.W(CW)) chk_sr_i (.clk(clk), .rst_n(rst_n), .shift_i(en_chk),
        .bit_i(bit_in), .q_o(chk_q), .nxt_o(chk_nxt));

    // Load the output fields and pulse valid when a packet completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code  <= '0;
            ext_code  <= '0;
            glob_cfg  <= '0;
            chk_code  <= '0;
            cfg_valid <= 1'b0;
        end else begin
            cfg_valid <= done;
            if (done) begin
                act_code <= act_q;
                ext_code <= ext_q;
                chk_code <= chk_nxt;
                if (long_q) glob_cfg <= glb_q;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid); // R6
    AST_SHORT_HOLDS_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && ext_code[SB]) |-> $stable(glob_cfg)); // R5
    AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rst_esc |=> !cfg_valid); // R7
    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> ($stable(act_code) && $stable(chk_code))); // R2
endmodule

// File: tb/selseq_rx_tb.sv
// Scoreboard bench: the driver pushes the expected packet contents and the
// negedge monitor compares them against every cfg_valid strobe.
module selseq_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, bit_in = 1'b0, sel_pulse = 1'b0, rst_esc = 1'b0;
    logic [3:0]  act_code, ext_code, chk_code;
    logic [23:0] glob_cfg;
    logic        cfg_valid;

    typedef struct packed {
        logic [3:0]  act;
        logic [3:0]  ext;
        logic [23:0] glb;
        logic [3:0]  chk;
    } item_t;

    item_t       exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [23:0] last_glb = '0;
    bit          done_flag = 0;

    always #2 clk = ~clk;

    selseq_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .sel_pulse(sel_pulse), .rst_esc(rst_esc), .act_code(act_code),
        .ext_code(ext_code), .glob_cfg(glob_cfg), .chk_code(chk_code),
        .cfg_valid(cfg_valid)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every valid strobe must match the oldest expected packet.
    always @(negedge clk) begin
        if (rst_n && cfg_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected cfg_valid", 32'(cfg_valid), 32'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk("R3 act_code", 32'(act_code), 32'(e.act));
                chk("R3 ext_code", 32'(ext_code), 32'(e.ext));
                chk("R4/R5 glob_cfg", 32'(glob_cfg), 32'(e.glb));
                chk("R6 chk_code", 32'(chk_code), 32'(e.chk));
            end
        end
    end

    // Drive one bit: strobe for one cycle, entered and left at a negedge.
    task automatic put_bit(logic b, logic esc);
        bit_in  = b;
        bit_stb = 1'b1;
        rst_esc = esc;
        @(negedge clk);
        bit_stb = 1'b0;
        rst_esc = 1'b0;
    endtask

    task automatic arm();
        sel_pulse = 1'b1;
        @(negedge clk);
        sel_pulse = 1'b0;
    endtask

    // Send a packet. abort_at < 0: completes; otherwise rst_esc goes with bit abort_at.
    task automatic send(logic [3:0] a, logic [3:0] x, logic [23:0] g, logic [3:0] c,
                        int gap, int abort_at);
        logic [35:0] bits;
        int          nb;
        item_t       e;
        if (x[3]) begin
            bits = {24'd0, c, x, a};
            nb   = 12;
        end else begin
            bits = {c, g, x, a};
            nb   = 36;
        end
        if (abort_at < 0) begin
            e.act = a; e.ext = x; e.chk = c;
            if (!x[3]) last_glb = g;
            e.glb = last_glb;
            exp_q.push_back(e);
        end
        arm();
        for (int i = 0; i < nb; i++) begin
            put_bit(bits[i], (i == abort_at));
            if (i == nb - 1 && abort_at < 0)
                chk("R6 valid after last check bit", 32'(cfg_valid), 32'd1);
            else if (i != nb - 1)
                repeat (gap) @(negedge clk);
        end
        @(negedge clk);
        chk("R6 valid lasts one cycle", 32'(cfg_valid), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cfg_valid", 32'(cfg_valid), 32'd0);
        chk("R1 act_code", 32'(act_code), 32'd0);
        chk("R1 ext_code", 32'(ext_code), 32'd0);
        chk("R1 glob_cfg", 32'(glob_cfg), 32'd0);
        chk("R1 chk_code", 32'(chk_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: bits while idle are ignored
        for (int i = 0; i < 40; i++) put_bit(i[0], 1'b0);
        chk("R2 idle act_code", 32'(act_code), 32'd0);
        chk("R2 idle glob_cfg", 32'(glob_cfg), 32'd0);

        // R9 / R4: all-zero long packet
        send(4'h0, 4'h0, 24'h000000, 4'h0, 0, -1);
        // R3 / R4: long packet, back-to-back strobes
        send(4'h5, 4'h6, 24'hA5C3_1E, 4'h9, 0, -1);
        // R4: long packet with gaps between strobes
        send(4'hE, 4'h1, 24'h3C_7F01, 4'h6, 2, -1);
        // R5: short packet keeps previous image
        send(4'h3, 4'hB, 24'hFFFFFF, 4'hC, 1, -1);
        send(4'hA, 4'h8, 24'h000000, 4'h1, 0, -1);

        // R7: abort halfway, then the remaining bits arrive unarmed
        send(4'h7, 4'h2, 24'h123456, 4'hF, 0, 17);
        chk("R7 outputs kept after abort", 32'(act_code), 32'hA);
        // R7: escape together with the final check bit
        send(4'h4, 4'h9, 24'h0, 4'h2, 0, 11);
        chk("R7 final-bit abort kept chk_code", 32'(chk_code), 32'h1);

        // R8: restart mid-packet, only the new packet counts
        arm();
        for (int i = 0; i < 10; i++) put_bit(1'b1, 1'b0);
        send(4'h2, 4'h4, 24'h0F0F0F, 4'h5, 0, -1);
        // R8: selection pulse with a strobe in the same cycle drops that bit
        sel_pulse = 1'b1; bit_stb = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        sel_pulse = 1'b0; bit_stb = 1'b0;
        send(4'h1, 4'hD, 24'h0, 4'h7, 0, -1);

        repeat (5) @(negedge clk);
        chk("R7 no stray packets left", 32'(exp_q.size()), 32'd0);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(negedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule